// File: doc/BRIEF.md
# Two-Register Stack Machine Execute Datapath

This block is the execute datapath of a compact stack processor. The two top stack entries sit in registers: `tos` is the top and `nos` is the entry below it. Deeper entries live in a word-wide stack RAM inside the block. A stack pointer, a variable pointer, a program-counter shadow register and an address register complete the state. An external decoder drives every select and enable line on every cycle. The block carries out that cycle's operation and updates its registers on the next rising clock edge.

The arithmetic unit is one adder that can also subtract. The decoder normally leaves it in subtract mode, so the equal and less-than flags (`nos` compared with `tos`) are valid in every cycle. A logic unit, a barrel shifter, immediate data, I/O read data and the internal pointer registers feed a load multiplexer into `tos`. Stack traffic between `tos`, `nos` and the RAM is steered by explicit encodings: push moves `tos` into `nos` and `nos` into the RAM, pop refills `nos` from the RAM, and a third encoding leaves the stack unchanged. The RAM read address and the RAM write address each come from their own address selector.

The block is pure datapath and contains no state machine. Every register is updated from the control inputs in a single cycle.

Top module: `stk_exec_core`

## Requirements
- R1: With `a_en`=1 and `a_src_ld`=0, `tos` takes `nos + tos` when `op_sub`=0 and `nos - tos` when `op_sub`=1, both modulo 2^DATA_W, at the next edge.
- R2: `tos` is unchanged when `a_en`=0, and `nos` is unchanged when `b_en`=0.
- R3: With `a_src_ld`=1 and `ld_sel`=000, `tos` takes the logic result selected by `logic_op`: 00 = `nos`, 01 = AND, 10 = OR, 11 = XOR of `nos` and `tos`.
- R4: With `ld_sel`=001, `tos` takes `nos` shifted by the low log2(DATA_W) bits of `tos`. `shift_op` selects the shift: 00 = logical right, 01 = left, 10 = arithmetic right, 11 = logical right.
- R5: `ld_sel` selects the load source: 010 = RAM read data, 011 = `imm_val`, 100 = `io_val`, 101 = the register mux. The codes 110 and 111 load zero.
- R6: `reg_sel` selects the register mux source: 00 = stack pointer (zero-extended), 01 = variable pointer, 10 = program-counter shadow, 11 = address register.
- R7: With `b_en`=1, `nos` takes `tos` when `b_src_ram`=0 (push) and the RAM read data when `b_src_ram`=1 (pop).
- R8: With `ram_we`=1, the word at the write address takes `tos` (`wdata_b`=0) or `nos` (`wdata_b`=1) at the edge. The word can be read from the next cycle onward.
- R9: `sp_op` updates the stack pointer: 00 = hold, 01 = minus one, 10 = plus one, 11 = load the low RAM_AW bits of `tos`. The result wraps modulo 2^RAM_AW.
- R10: The address select codes are the same for `rd_sel` and `wr_sel`. Codes 0..3 give variable pointer + 0..3, code 4 gives variable pointer + the low RAM_AW bits of `imm_val`, and code 5 gives the address register. Code 6 gives the stack pointer for reads and stack pointer + 1 for writes.
- R11: Select code 7 gives the direct address `dir_const`*32 + `dir_idx`, so constants sit at 32..63 and variables at 0..31.
- R12: When `vp_en`, `pcs_en` or `ar_en` is high, the variable pointer, the program-counter shadow or the address register loads from `tos`. The pointers take the low RAM_AW bits of `tos`.
- R13: `flag_zero` is high when `tos` is zero, and `flag_neg` is the top bit of `tos`. With `op_sub`=1, `flag_eq` shows `nos == tos` and `flag_lt` shows signed `nos < tos`. All four flags are combinational.
- R14: Reset (`rst_n` low) clears `tos`, `nos`, the variable pointer, the program-counter shadow and the address register to zero, and sets the stack pointer to SP_INIT (default 128).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sub | input | 1 | 0 = add, 1 = subtract (`nos - tos`) |
| a_src_ld | input | 1 | `tos` source: 0 = adder, 1 = load mux |
| a_en | input | 1 | `tos` write enable |
| b_src_ram | input | 1 | `nos` source: 0 = `tos`, 1 = RAM read data |
| b_en | input | 1 | `nos` write enable |
| logic_op | input | 2 | Logic unit function |
| shift_op | input | 2 | Shifter function |
| ld_sel | input | 3 | Load mux select |
| reg_sel | input | 2 | Register mux select |
| sp_op | input | 2 | Stack pointer update |
| wdata_b | input | 1 | RAM write data: 0 = `tos`, 1 = `nos` |
| ram_we | input | 1 | Stack RAM write enable |
| rd_sel | input | 3 | Read address select |
| wr_sel | input | 3 | Write address select |
| dir_const | input | 1 | Direct address region: 1 = constants |
| dir_idx | input | 5 | Direct address index |
| vp_en | input | 1 | Variable pointer load enable |
| pcs_en | input | 1 | Program-counter shadow load enable |
| ar_en | input | 1 | Address register load enable |
| imm_val | input | DATA_W | Immediate operand |
| io_val | input | DATA_W | I/O read data |
| tos | output | DATA_W | Top of stack register |
| nos | output | DATA_W | Next-on-stack register |
| sp_val | output | RAM_AW | Stack pointer |
| flag_zero | output | 1 | `tos` is zero |
| flag_neg | output | 1 | Sign bit of `tos` |
| flag_eq | output | 1 | `nos == tos` (valid in subtract mode) |
| flag_lt | output | 1 | Signed `nos < tos` (valid in subtract mode) |

## Verification
Register results are due one edge after their controls are applied: `tos`, `nos`, the stack pointer, the pointer registers and RAM words. A RAM word or a pointer register is seen only through a later load into `tos`, so it shows two edges after the cycle that wrote it. The bench drives every control 1 ns after a rising edge. It reads the register outputs 1 ns after the following edge, never at the edge itself. The flags depend only on the current `tos`, `nos` and `op_sub`, so the bench checks them in the same cycle after a 1 ns settle, with no clock edge between.

// File: rtl/stk_exec_pkg.sv
package stk_exec_pkg;

    typedef enum logic [1:0] {
        LG_PASS_B = 2'b00,
        LG_AND    = 2'b01,
        LG_OR     = 2'b10,
        LG_XOR    = 2'b11
    } logic_op_e;

    typedef enum logic [1:0] {
        SH_SRL     = 2'b00,
        SH_SLL     = 2'b01,
        SH_SRA     = 2'b10,
        SH_SRL_ALT = 2'b11
    } shift_op_e;

    typedef enum logic [2:0] {
        LD_LOGIC = 3'd0,
        LD_SHIFT = 3'd1,
        LD_RAM   = 3'd2,
        LD_IMM   = 3'd3,
        LD_IO    = 3'd4,
        LD_REG   = 3'd5,
        LD_RSV6  = 3'd6,
        LD_RSV7  = 3'd7
    } ld_sel_e;

    typedef enum logic [1:0] {
        RG_SP  = 2'b00,
        RG_VP  = 2'b01,
        RG_PCS = 2'b10,
        RG_AR  = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        SP_HOLD = 2'b00,
        SP_DEC  = 2'b01,
        SP_INC  = 2'b10,
        SP_LOAD = 2'b11
    } sp_op_e;

    // address select codes shared by the read and write selectors
    localparam logic [2:0] AS_VP_IMM = 3'd4;
    localparam logic [2:0] AS_AR     = 3'd5;
    localparam logic [2:0] AS_SP     = 3'd6;
    localparam logic [2:0] AS_DIRECT = 3'd7;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_exec_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              op_sub,
    input  logic [1:0]        logic_op,
    input  logic [1:0]        shift_op,
    output logic [DATA_W-1:0] sum_res,
    output logic [DATA_W-1:0] log_res,
    output logic [DATA_W-1:0] shf_res,
    output logic              eq_flag,
    output logic              lt_flag
);

    localparam int unsigned SHAMT_W = $clog2(DATA_W);

    logic [DATA_W:0]      ext_a;
    logic [DATA_W:0]      ext_b;
    logic [DATA_W:0]      addend;
    logic [DATA_W:0]      sum_x;
    logic [SHAMT_W-1:0]   shamt;

    // one sign-extended adder; subtract forms b + ~a + 1
    always_comb begin
        ext_a   = {a_in[DATA_W-1], a_in};
        ext_b   = {b_in[DATA_W-1], b_in};
        addend  = op_sub ? ~ext_a : ext_a;
        sum_x   = ext_b + addend + {{DATA_W{1'b0}}, op_sub};
        sum_res = sum_x[DATA_W-1:0];
        eq_flag = (sum_x[DATA_W-1:0] == '0);
        lt_flag = sum_x[DATA_W];
    end

    always_comb begin
        unique case (logic_op_e'(logic_op))
            LG_PASS_B: log_res = b_in;
            LG_AND:    log_res = b_in & a_in;
            LG_OR:     log_res = b_in | a_in;
            LG_XOR:    log_res = b_in ^ a_in;
        endcase
    end

    always_comb begin
        shamt = a_in[SHAMT_W-1:0];
        unique case (shift_op_e'(shift_op))
            SH_SRL:     shf_res = b_in >> shamt;
            SH_SLL:     shf_res = b_in << shamt;
            SH_SRA:     shf_res = DATA_W'($signed(b_in) >>> shamt);
            SH_SRL_ALT: shf_res = b_in >> shamt;
        endcase
    end

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
    import stk_exec_pkg::*;
#(
    parameter int unsigned RAM_AW     = 8,
    parameter bit          WRITE_PORT = 1'b0
) (
    input  logic [2:0]        sel,
    input  logic [RAM_AW-1:0] vp,
    input  logic [RAM_AW-1:0] ar,
    input  logic [RAM_AW-1:0] sp,
    input  logic [RAM_AW-1:0] imm_ofs,
    input  logic              dir_const,
    input  logic [4:0]        dir_idx,
    output logic [RAM_AW-1:0] addr
);

    logic [RAM_AW-1:0] sp_term;
    logic [RAM_AW-1:0] dir_addr;

    // the write side addresses the free slot above the stack pointer
    generate
        if (WRITE_PORT) begin : g_wr_side
            assign sp_term = sp + RAM_AW'(1);
        end else begin : g_rd_side
            assign sp_term = sp;
        end
    endgenerate

    assign dir_addr = RAM_AW'({dir_const, dir_idx});

    always_comb begin
        unique case (sel)
            AS_VP_IMM: addr = vp + imm_ofs;
            AS_AR:     addr = ar;
            AS_SP:     addr = sp_term;
            AS_DIRECT: addr = dir_addr;
            default:   addr = vp + RAM_AW'(sel[1:0]);
        endcase
    end

endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RAM_AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RAM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/stk_exec_core.sv
module stk_exec_core
    import stk_exec_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned RAM_AW  = 8,
    parameter int unsigned SP_INIT = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_sub,
    input  logic              a_src_ld,
    input  logic              a_en,
    input  logic              b_src_ram,
    input  logic              b_en,
    input  logic [1:0]        logic_op,
    input  logic [1:0]        shift_op,
    input  logic [2:0]        ld_sel,
    input  logic [1:0]        reg_sel,
    input  logic [1:0]        sp_op,
    input  logic              wdata_b,
    input  logic              ram_we,
    input  logic [2:0]        rd_sel,
    input  logic [2:0]        wr_sel,
    input  logic              dir_const,
    input  logic [4:0]        dir_idx,
    input  logic              vp_en,
    input  logic              pcs_en,
    input  logic              ar_en,
    input  logic [DATA_W-1:0] imm_val,
    input  logic [DATA_W-1:0] io_val,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic [RAM_AW-1:0] sp_val,
    output logic              flag_zero,
    output logic              flag_neg,
    output logic              flag_eq,
    output logic              flag_lt
);

    localparam logic [RAM_AW-1:0] SP_RESET = RAM_AW'(SP_INIT);

    logic [DATA_W-1:0] a_q, b_q, pcs_q;
    logic [RAM_AW-1:0] sp_q, vp_q, ar_q;

    logic [DATA_W-1:0] sum_res, log_res, shf_res;
    logic [DATA_W-1:0] ram_rdata, ram_wdata;
    logic [DATA_W-1:0] reg_res, ld_res;
    logic [DATA_W-1:0] a_nxt, b_nxt;
    logic [RAM_AW-1:0] sp_nxt;
    logic [RAM_AW-1:0] rd_addr, wr_addr;
    logic              eq_w, lt_w;

    stk_alu #(.DATA_W(DATA_W)) u_alu (
        .a_in     (a_q),
        .b_in     (b_q),
        .op_sub   (op_sub),
        .logic_op (logic_op),
        .shift_op (shift_op),
        .sum_res  (sum_res),
        .log_res  (log_res),
        .shf_res  (shf_res),
        .eq_flag  (eq_w),
        .lt_flag  (lt_w)
    );

    stk_addr_gen #(.RAM_AW(RAM_AW), .WRITE_PORT(1'b0)) u_rd_addr (
        .sel       (rd_sel),
        .vp        (vp_q),
        .ar        (ar_q),
        .sp        (sp_q),
        .imm_ofs   (imm_val[RAM_AW-1:0]),
        .dir_const (dir_const),
        .dir_idx   (dir_idx),
        .addr      (rd_addr)
    );

    stk_addr_gen #(.RAM_AW(RAM_AW), .WRITE_PORT(1'b1)) u_wr_addr (
        .sel       (wr_sel),
        .vp        (vp_q),
        .ar        (ar_q),
        .sp        (sp_q),
        .imm_ofs   (imm_val[RAM_AW-1:0]),
        .dir_const (dir_const),
        .dir_idx   (dir_idx),
        .addr      (wr_addr)
    );

    assign ram_wdata = wdata_b ? b_q : a_q;

    stk_ram #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (wr_addr),
        .wdata (ram_wdata),
        .raddr (rd_addr),
        .rdata (ram_rdata)
    );

    // register mux
    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            RG_SP:  reg_res = DATA_W'(sp_q);
            RG_VP:  reg_res = DATA_W'(vp_q);
            RG_PCS: reg_res = pcs_q;
            RG_AR:  reg_res = DATA_W'(ar_q);
        endcase
    end

    // load mux
    always_comb begin
        unique case (ld_sel_e'(ld_sel))
            LD_LOGIC: ld_res = log_res;
            LD_SHIFT: ld_res = shf_res;
            LD_RAM:   ld_res = ram_rdata;
            LD_IMM:   ld_res = imm_val;
            LD_IO:    ld_res = io_val;
            LD_REG:   ld_res = reg_res;
            LD_RSV6:  ld_res = '0;
            LD_RSV7:  ld_res = '0;
        endcase
    end

    // next-value logic
    always_comb begin
        a_nxt = a_src_ld ? ld_res : sum_res;
        b_nxt = b_src_ram ? ram_rdata : a_q;
        unique case (sp_op_e'(sp_op))
            SP_HOLD: sp_nxt = sp_q;
            SP_DEC:  sp_nxt = sp_q - RAM_AW'(1);
            SP_INC:  sp_nxt = sp_q + RAM_AW'(1);
            SP_LOAD: sp_nxt = a_q[RAM_AW-1:0];
        endcase
    end

    // register bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            pcs_q <= '0;
            vp_q  <= '0;
            ar_q  <= '0;
            sp_q  <= SP_RESET;
        end else begin
            if (a_en)   a_q   <= a_nxt;
            if (b_en)   b_q   <= b_nxt;
            if (pcs_en) pcs_q <= a_q;
            if (vp_en)  vp_q  <= a_q[RAM_AW-1:0];
            if (ar_en)  ar_q  <= a_q[RAM_AW-1:0];
            sp_q <= sp_nxt;
        end
    end

    // outputs
    always_comb begin
        tos       = a_q;
        nos       = b_q;
        sp_val    = sp_q;
        flag_zero = (a_q == '0);
        flag_neg  = a_q[DATA_W-1];
        flag_eq   = eq_w;
        flag_lt   = lt_w;
    end

endmodule

// File: rtl/stk_exec_core_chk.sv
module stk_exec_core_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RAM_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_en,
    input logic              b_en,
    input logic              b_src_ram,
    input logic              op_sub,
    input logic [1:0]        sp_op,
    input logic [DATA_W-1:0] tos,
    input logic [DATA_W-1:0] nos,
    input logic [RAM_AW-1:0] sp_val,
    input logic              flag_eq,
    input logic              flag_lt
);

    p_a_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> tos == $past(tos));

    p_b_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> nos == $past(nos));

    p_b_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && !b_src_ram) |=> nos == $past(tos));

    p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == 2'b00) |=> sp_val == $past(sp_val));

    p_sp_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == 2'b10) |=> sp_val == $past(sp_val) + RAM_AW'(1));

    p_sp_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == 2'b01) |=> sp_val == $past(sp_val) - RAM_AW'(1));

    p_sp_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == 2'b11) |=> sp_val == $past(tos[RAM_AW-1:0]));

    p_eq_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
        op_sub |-> flag_eq == (nos == tos));

    p_lt_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
        op_sub |-> flag_lt == ($signed(nos) < $signed(tos)));

endmodule

bind stk_exec_core stk_exec_core_chk #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_en      (a_en),
    .b_en      (b_en),
    .b_src_ram (b_src_ram),
    .op_sub    (op_sub),
    .sp_op     (sp_op),
    .tos       (tos),
    .nos       (nos),
    .sp_val    (sp_val),
    .flag_eq   (flag_eq),
    .flag_lt   (flag_lt)
);

// File: tb/stk_exec_core_test.sv
`timescale 1ns/100ps
module stk_exec_core_test;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 8;
    localparam logic [DW-1:0] IMM_K = 32'hCAFE0001;
    localparam logic [DW-1:0] IO_K  = 32'h10C0FFEE;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [8:0]  ctl;   // {op_sub, a_src_ld, logic_op[1:0], shift_op[1:0], ld_sel[2:0]}
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'd5,        32'd7,        9'h000, 32'd12,       8'd1}, // R1 add
        '{32'd5,        32'd7,        9'h100, 32'd2,        8'd1}, // R1 sub
        '{32'd7,        32'd5,        9'h100, 32'hFFFFFFFE, 8'd1}, // R1 sub negative
        '{32'hFFFFFFFF, 32'd1,        9'h000, 32'd0,        8'd1}, // R1 add wrap
        '{32'h0000F0F0, 32'h00001234, 9'h080, 32'h00001234, 8'd3}, // R3 pass
        '{32'h0000FF00, 32'h12345678, 9'h0A0, 32'h00005600, 8'd3}, // R3 and
        '{32'h0F000000, 32'h12345678, 9'h0C0, 32'h1F345678, 8'd3}, // R3 or
        '{32'hFFFFFFFF, 32'h12345678, 9'h0E0, 32'hEDCBA987, 8'd3}, // R3 xor
        '{32'd4,        32'h80000010, 9'h081, 32'h08000001, 8'd4}, // R4 srl
        '{32'd8,        32'h000000AB, 9'h089, 32'h0000AB00, 8'd4}, // R4 sll
        '{32'd4,        32'h80000010, 9'h091, 32'hF8000001, 8'd4}, // R4 sra
        '{32'd31,       32'h80000000, 9'h099, 32'h00000001, 8'd4}, // R4 code 11
        '{32'h24,       32'd1,        9'h089, 32'h00000010, 8'd4}, // R4 amount low bits
        '{32'd9,        32'd3,        9'h083, IMM_K,        8'd5}, // R5 immediate
        '{32'd9,        32'd3,        9'h084, IO_K,         8'd5}, // R5 io
        '{32'd9,        32'd3,        9'h086, 32'd0,        8'd5}  // R5 reserved
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_sub, a_src_ld, a_en, b_src_ram, b_en;
    logic [1:0]    logic_op, shift_op, reg_sel, sp_op;
    logic [2:0]    ld_sel, rd_sel, wr_sel;
    logic          wdata_b, ram_we, dir_const, vp_en, pcs_en, ar_en;
    logic [4:0]    dir_idx;
    logic [DW-1:0] imm_val, io_val;
    logic [DW-1:0] tos, nos;
    logic [AW-1:0] sp_val;
    logic          flag_zero, flag_neg, flag_eq, flag_lt;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    stk_exec_core #(.DATA_W(DW), .RAM_AW(AW), .SP_INIT(128)) uut (
        .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .a_src_ld(a_src_ld), .a_en(a_en),
        .b_src_ram(b_src_ram), .b_en(b_en), .logic_op(logic_op), .shift_op(shift_op),
        .ld_sel(ld_sel), .reg_sel(reg_sel), .sp_op(sp_op), .wdata_b(wdata_b),
        .ram_we(ram_we), .rd_sel(rd_sel), .wr_sel(wr_sel), .dir_const(dir_const),
        .dir_idx(dir_idx), .vp_en(vp_en), .pcs_en(pcs_en), .ar_en(ar_en),
        .imm_val(imm_val), .io_val(io_val), .tos(tos), .nos(nos), .sp_val(sp_val),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_eq(flag_eq), .flag_lt(flag_lt)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        op_sub = 0; a_src_ld = 0; a_en = 0; b_src_ram = 0; b_en = 0;
        logic_op = 0; shift_op = 0; ld_sel = 0; reg_sel = 0; sp_op = 0;
        wdata_b = 0; ram_we = 0; rd_sel = 0; wr_sel = 0; dir_const = 0;
        dir_idx = 0; vp_en = 0; pcs_en = 0; ar_en = 0;
        imm_val = 0; io_val = IO_K;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_imm(input logic [DW-1:0] v);
        imm_val = v; a_src_ld = 1; ld_sel = 3'b011; a_en = 1;
        b_en = 1; b_src_ram = 0; ram_we = 1; wr_sel = 3'd6; wdata_b = 1; sp_op = 2'b10;
        step();
        idle();
    endtask

    // load tos from RAM through the read selector
    task automatic read_ram(input logic [2:0] sel, input logic [DW-1:0] imm);
        a_src_ld = 1; ld_sel = 3'b010; a_en = 1; rd_sel = sel; imm_val = imm;
        step();
        idle();
    endtask

    task automatic read_reg(input logic [1:0] sel);
        a_src_ld = 1; ld_sel = 3'b101; reg_sel = sel; a_en = 1;
        step();
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] sp_before;
        idle();
        repeat (3) @(posedge clk);
        #1;
        // R14 reset state
        chk("R14 tos reset", tos, '0);
        chk("R14 nos reset", nos, '0);
        chk("R14 sp reset", DW'(sp_val), 32'd128);
        chk("R13 zero flag at reset", DW'(flag_zero), 32'd1);
        rst_n = 1;
        step();
        chk("R14 sp held after reset", DW'(sp_val), 32'd128);

        // push sequence: R7 push path, R9 increment
        push_imm(32'd7);
        push_imm(32'd5);
        chk("R7 nos from tos on push", nos, 32'd7);
        chk("R5 tos from immediate", tos, 32'd5);
        chk("R9 sp increment", DW'(sp_val), 32'd130);

        // R13 flags
        op_sub = 1; #1;
        chk("R13 eq 7 vs 5", DW'(flag_eq), 32'd0);
        chk("R13 lt 7<5", DW'(flag_lt), 32'd0);
        chk("R13 zero nonzero tos", DW'(flag_zero), 32'd0);
        op_sub = 0;
        push_imm(32'd7);
        op_sub = 1; #1;
        chk("R13 lt 5<7", DW'(flag_lt), 32'd1);
        op_sub = 0;
        push_imm(32'd7);
        op_sub = 1; #1;
        chk("R13 eq 7==7", DW'(flag_eq), 32'd1);
        chk("R13 lt 7<7", DW'(flag_lt), 32'd0);
        op_sub = 0;
        push_imm(32'h80000000);
        push_imm(32'd1);
        op_sub = 1; #1;
        chk("R13 signed lt min<1", DW'(flag_lt), 32'd1);
        chk("R13 neg clear", DW'(flag_neg), 32'd0);
        op_sub = 0;
        push_imm(32'hFFFFFFFF);
        op_sub = 1; #1;
        chk("R13 neg set", DW'(flag_neg), 32'd1);
        chk("R13 signed lt 1<-1", DW'(flag_lt), 32'd0);
        op_sub = 0;

        // vector table, no-stack-change operations: R1 R3 R4 R5 and nos hold R2
        for (int i = 0; i < NV; i++) begin
            push_imm(VECS[i].b);
            push_imm(VECS[i].a);
            op_sub   = VECS[i].ctl[8];
            a_src_ld = VECS[i].ctl[7];
            logic_op = VECS[i].ctl[6:5];
            shift_op = VECS[i].ctl[4:3];
            ld_sel   = VECS[i].ctl[2:0];
            imm_val  = IMM_K;
            io_val   = IO_K;
            a_en     = 1;
            step();
            idle();
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), tos, VECS[i].exp);
            chk($sformatf("R2 nos hold vector %0d", i), nos, VECS[i].b);
        end

        // R2 tos hold with a_en low
        push_imm(32'h0000ABCD);
        a_src_ld = 1; ld_sel = 3'b011; imm_val = 32'hDEAD; a_en = 0; b_en = 0;
        step();
        idle();
        chk("R2 tos hold", tos, 32'h0000ABCD);

        // pop: R7 RAM path, R9 decrement, R10 read at sp
        push_imm(32'h11);
        push_imm(32'h22);
        push_imm(32'h33);
        sp_before = sp_val;
        a_en = 1; b_en = 1; b_src_ram = 1; rd_sel = 3'd6; sp_op = 2'b01;
        step();
        idle();
        chk("R1 pop add", tos, 32'h55);
        chk("R7 nos from RAM on pop", nos, 32'h11);
        chk("R9 sp decrement", DW'(sp_val), DW'(sp_before - AW'(1)));

        // R11 direct addressing, R8 write of tos
        push_imm(32'h3333);
        ram_we = 1; wr_sel = 3'd7; dir_const = 0; dir_idx = 5'd3; wdata_b = 0;
        step(); idle();
        push_imm(32'h3535);
        ram_we = 1; wr_sel = 3'd7; dir_const = 1; dir_idx = 5'd3; wdata_b = 0;
        step(); idle();
        dir_const = 0; dir_idx = 5'd3;
        a_src_ld = 1; ld_sel = 3'b010; a_en = 1; rd_sel = 3'd7;
        step(); idle();
        chk("R11 variable region addr 3", tos, 32'h3333);
        dir_const = 1; dir_idx = 5'd3;
        a_src_ld = 1; ld_sel = 3'b010; a_en = 1; rd_sel = 3'd7;
        step(); idle();
        chk("R11 constant region addr 35", tos, 32'h3535);

        // R8 write of nos via write select
        push_imm(32'h7777);
        push_imm(32'h8888);
        ram_we = 1; wr_sel = 3'd7; dir_const = 0; dir_idx = 5'd9; wdata_b = 1;
        step(); idle();
        dir_idx = 5'd9;
        read_ram(3'd7, 32'd0);
        chk("R8 nos written as data", tos, 32'h7777);

        // R12 vp, R6 reg mux, R10 vp-relative addressing
        push_imm(32'h40);
        vp_en = 1; step(); idle();
        read_reg(2'b01);
        chk("R12 vp load R6 reg mux vp", tos, 32'h40);
        push_imm(32'hBEEF);
        ram_we = 1; wr_sel = 3'd2; wdata_b = 0; step(); idle();
        push_imm(32'h4343);
        ram_we = 1; wr_sel = 3'd3; wdata_b = 0; step(); idle();
        push_imm(32'h4545);
        ram_we = 1; wr_sel = 3'd4; imm_val = 32'd5; wdata_b = 0; step(); idle();
        push_imm(32'd1);
        read_ram(3'd2, 32'd0);
        chk("R10 read vp+2", tos, 32'hBEEF);
        read_ram(3'd3, 32'd0);
        chk("R10 read vp+3", tos, 32'h4343);
        read_ram(3'd4, 32'd2);
        chk("R10 read vp+imm 2", tos, 32'hBEEF);
        read_ram(3'd4, 32'd5);
        chk("R10 write vp+imm 5", tos, 32'h4545);

        // R12 ar and R10 code 5, R6 code 3
        push_imm(32'h42);
        ar_en = 1; step(); idle();
        push_imm(32'd1);
        read_ram(3'd5, 32'd0);
        chk("R10 read via ar", tos, 32'hBEEF);
        read_reg(2'b11);
        chk("R6 reg mux ar", tos, 32'h42);

        // R12 pcs, R6 code 2
        push_imm(32'h12345678);
        pcs_en = 1; step(); idle();
        push_imm(32'd0);
        read_reg(2'b10);
        chk("R6 reg mux pcs", tos, 32'h12345678);

        // R6 code 0 stack pointer
        sp_before = sp_val;
        read_reg(2'b00);
        chk("R6 reg mux sp", tos, DW'(sp_before));
        chk("R9 sp hold", DW'(sp_val), DW'(sp_before));

        // R9 load and wrap
        push_imm(32'h20);
        sp_op = 2'b11; step(); idle();
        chk("R9 sp load from tos", DW'(sp_val), 32'h20);
        push_imm(32'h0);
        sp_op = 2'b11; step(); idle();
        sp_op = 2'b01; step(); idle();
        chk("R9 sp wrap down", DW'(sp_val), 32'hFF);
        sp_op = 2'b10; step(); idle();
        chk("R9 sp wrap up", DW'(sp_val), 32'h00);

        // R14 reset mid-run
        rst_n = 0; #1;
        chk("R14 tos async clear", tos, '0);
        chk("R14 sp async init", DW'(sp_val), 32'd128);
        step();
        rst_n = 1;
        step();
        read_reg(2'b01);
        chk("R14 vp cleared", tos, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule